// File: doc/BRIEF.md
# Byte FIFO with Level and Frame Interrupts

This block is a small byte queue placed between a host register port and the transmit/receive framing logic of a contactless reader. In transmit mode the host loads bytes and the framer drains them; in receive mode the framer loads bytes and the host drains them. The direction input picks which side may push and which may pop. Strobes from the other side are ignored.

A status port reports how full the queue is. The level field holds the number of bytes held minus one. Separate empty and full bits remove the ambiguity at zero. A sticky flag register gathers the block's events:
- transmit start and end
- receive end of frame
- the level mark
- error pulses from the framer (CRC, parity, framing)
- overflow and underflow

Each flag is masked by its own enable bit. A single interrupt line is the OR of the enabled flags. Reading the status clears the flags.

The level mark depends on direction. While transmitting, the flag fires when the framer's pops bring the queue down to a low-water count, so the host can refill. While receiving, it fires only when a frame grows past a threshold. A short frame therefore raises only the end-of-frame flag.

The block also holds a transmit byte-length register. That register clears itself when transmission ends.

Top module: `xfifo_top`

## Requirements
- R1: After reset the queue is empty: status reads 0x10, with bit 4 = empty and level code 0. Flags, irq and the length register read 0. The enable mask reads 0x3C, so the level, CRC, parity and framing enables are 1 and the others are 0.
- R2: With dir_tx=1 only host_push and frm_pop act. With dir_tx=0 only frm_push and host_pop act. Strobes from the inactive side change nothing, and the inactive side's read-data output reads 0.
- R3: Bytes leave in the order they entered. Status bits 3:0 hold the count minus one (8 bytes read 7, empty reads 0). Bit 4 is empty and bit 5 is full, so a full 12-entry queue reads 0x2B.
- R4: A push while full drops the byte, leaves the count unchanged and sets flag bit 6 (overflow).
- R5: A pop while empty returns 0, leaves the count at 0 and sets flag bit 7 (underflow).
- R6: flush empties the queue in one cycle and overrides any push or pop in that cycle.
- R7: In transmit mode, a pop that takes the count from 4 to 3 (without a push in the same cycle) sets flag bit 2 (level). No other transmit-mode transition sets it.
- R8: In receive mode, a push that takes the count from 8 to 9 sets flag bit 2. A frame of 8 bytes or fewer sets only flag bit 1, when rx_eof pulses.
- R9: tx_start sets flag bit 0 and the status shows it at once. Bit 0 drives irq only after tx_done has pulsed.
- R10: Pulses on err_crc, err_par and err_frm set flag bits 3, 4 and 5 respectively.
- R11: irq is high exactly when some flag is set together with its enable bit (bit 0 also waits for tx_done, as in R9). A stat_rd pulse clears all flags on the next cycle, except a flag set in that same cycle, which stays set.
- R12: The transmit length register takes txlen_wdata on txlen_wr and clears on tx_done. If both arrive in one cycle, the write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_tx | input | 1 | 1 = transmit (host loads, framer drains), 0 = receive |
| flush | input | 1 | Empty the queue |
| host_push | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write byte |
| host_pop | input | 1 | Host read strobe |
| host_rdata | output | 8 | Head byte to host (receive mode, else 0) |
| frm_push | input | 1 | Framer write strobe |
| frm_wdata | input | 8 | Framer write byte |
| frm_pop | input | 1 | Framer read strobe |
| frm_rdata | output | 8 | Head byte to framer (transmit mode, else 0) |
| tx_start | input | 1 | Transmission begins |
| tx_done | input | 1 | Transmission end of frame |
| rx_eof | input | 1 | Reception end of frame |
| err_crc | input | 1 | CRC error pulse |
| err_par | input | 1 | Parity error pulse |
| err_frm | input | 1 | Framing error pulse |
| en_wr | input | 1 | Write the enable mask |
| en_wdata | input | 8 | New enable mask |
| en_q | output | 8 | Current enable mask |
| stat_rd | input | 1 | Status read; clears flags |
| stat_level | output | 6 | {full, empty, count-1} |
| stat_flags | output | 8 | Sticky flags |
| irq | output | 1 | Interrupt request |
| txlen_wr | input | 1 | Write the transmit length |
| txlen_wdata | input | 12 | Transmit length value |
| txlen_q | output | 12 | Transmit length register |

## Verification
The bench uses the default parameters: 12 entries, a transmit low-water mark of 3, a receive threshold of 8 and a 12-bit length. With these, a full queue and its overflow take only a dozen pushes. The level code reaches its largest value, 11, in the 4-bit field. The transmit mark (4 to 3) and the receive threshold (8 to 9) both fall on exact single-pop and single-push transitions. Each is checked on the cycle before and the cycle after it fires.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

    localparam int BYTE_W = 8;
    localparam int NFLAG  = 8;

    // flag bit positions (status flag register layout)
    localparam int FB_TXEND = 0;
    localparam int FB_RXEND = 1;
    localparam int FB_LEVEL = 2;
    localparam int FB_CRC   = 3;
    localparam int FB_PAR   = 4;
    localparam int FB_FRM   = 5;
    localparam int FB_OVF   = 6;
    localparam int FB_UDF   = 7;

    typedef logic [NFLAG-1:0]  flag_vec_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // level, CRC, parity and framing enables come up set
    localparam flag_vec_t EN_RESET = flag_vec_t'((1 << FB_LEVEL) | (1 << FB_CRC) |
                                                 (1 << FB_PAR)   | (1 << FB_FRM));

    typedef enum logic {DIR_RX = 1'b0, DIR_TX = 1'b1} dir_e;

    // request bundle from whichever side currently feeds or drains the queue
    typedef struct packed {
        logic  push;
        logic  pop;
        byte_t wdata;
    } side_req_t;

    function automatic flag_vec_t bit_mask(input int pos, input logic on);
        flag_vec_t m;
        m = '0;
        m[pos] = on;
        return m;
    endfunction

endpackage

// File: rtl/xfifo_store.sv
module xfifo_store
    import xfifo_pkg::*;
#(
    parameter  int DEPTH = 12,
    localparam int PTRW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNTW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            flush,
    input  logic            push,
    input  logic            pop,
    input  byte_t           wdata,
    output byte_t           rdata,
    output logic [CNTW-1:0] count,
    output logic            push_ok,
    output logic            pop_ok,
    output logic            ovf_ev,
    output logic            udf_ev,
    output logic            full,
    output logic            empty
);

    localparam logic [PTRW-1:0] LAST = PTRW'(DEPTH - 1);

    byte_t           mem [DEPTH];
    logic [PTRW-1:0] wr_ptr, rd_ptr;
    logic [CNTW-1:0] cnt;

    function automatic logic [PTRW-1:0] step(input logic [PTRW-1:0] p);
        return (p == LAST) ? '0 : p + PTRW'(1);
    endfunction

    assign full    = (cnt == CNTW'(DEPTH));
    assign empty   = (cnt == '0);
    assign push_ok = push && !full  && !flush;
    assign pop_ok  = pop  && !empty && !flush;
    assign ovf_ev  = push && full  && !flush;
    assign udf_ev  = pop  && empty && !flush;
    assign count   = cnt;
    assign rdata   = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_ok) wr_ptr <= step(wr_ptr);
            if (pop_ok)  rd_ptr <= step(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + CNTW'(1);
                2'b01:   cnt <= cnt - CNTW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNTW'(DEPTH));

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !flush) |=> (cnt == CNTW'(DEPTH)));

    a_r5_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push && !flush) |=> (cnt == '0));

    a_r6_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty);

endmodule

// File: rtl/xfifo_flags.sv
module xfifo_flags
    import xfifo_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      stat_rd,
    input  flag_vec_t set_vec,
    input  logic      tx_done,
    input  logic      en_wr,
    input  flag_vec_t en_wdata,
    output flag_vec_t flags,
    output flag_vec_t en,
    output logic      irq
);

    logic      tx_fin;
    flag_vec_t gate;

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)             flags[i] <= 1'b0;
            else if (set_vec[i]) flags[i] <= 1'b1;
            else if (stat_rd)    flags[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          tx_fin <= 1'b0;
        else if (tx_done) tx_fin <= 1'b1;
        else if (stat_rd) tx_fin <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)        en <= EN_RESET;
        else if (en_wr) en <= en_wdata;
    end

    always_comb begin
        gate           = '1;
        gate[FB_TXEND] = tx_fin;
    end

    assign irq = |(flags & en & gate);

    a_r11_read_clears: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && set_vec == '0) |=> (flags == '0));

    a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));

    a_r9_tx_irq_waits: assert property (@(posedge clk) disable iff (rst)
        (set_vec == bit_mask(FB_TXEND, 1'b1) && flags == '0 && !tx_fin && !tx_done && !en_wr)
        |=> !irq);

endmodule

// File: rtl/xfifo_txlen.sv
module xfifo_txlen #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [LEN_W-1:0] wdata,
    input  logic             tx_done,
    output logic [LEN_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)          q <= '0;
        else if (wr)      q <= wdata;
        else if (tx_done) q <= '0;
    end

    a_r12_eof_clears: assert property (@(posedge clk) disable iff (rst)
        (tx_done && !wr) |=> (q == '0));

    a_r12_write_wins: assert property (@(posedge clk) disable iff (rst)
        wr |=> (q == $past(wdata)));

endmodule

// File: rtl/xfifo_top.sv
module xfifo_top
    import xfifo_pkg::*;
#(
    parameter  int DEPTH   = 12,
    parameter  int TX_LOW  = 3,
    parameter  int RX_HIGH = 8,
    parameter  int LEN_W   = 12,
    localparam int LVLW    = $clog2(DEPTH),
    localparam int CNTW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dir_tx,
    input  logic             flush,
    input  logic             host_push,
    input  logic [7:0]       host_wdata,
    input  logic             host_pop,
    output logic [7:0]       host_rdata,
    input  logic             frm_push,
    input  logic [7:0]       frm_wdata,
    input  logic             frm_pop,
    output logic [7:0]       frm_rdata,
    input  logic             tx_start,
    input  logic             tx_done,
    input  logic             rx_eof,
    input  logic             err_crc,
    input  logic             err_par,
    input  logic             err_frm,
    input  logic             en_wr,
    input  logic [7:0]       en_wdata,
    output logic [7:0]       en_q,
    input  logic             stat_rd,
    output logic [LVLW+1:0]  stat_level,
    output logic [7:0]       stat_flags,
    output logic             irq,
    input  logic             txlen_wr,
    input  logic [LEN_W-1:0] txlen_wdata,
    output logic [LEN_W-1:0] txlen_q
);

    dir_e            dir;
    side_req_t       req;
    byte_t           head;
    logic [CNTW-1:0] count;
    logic            push_ok, pop_ok, ovf_ev, udf_ev, full, empty;
    logic            lvl_ev;
    flag_vec_t       set_vec;
    logic [LVLW-1:0] lvl_code;

    assign dir = dir_e'(dir_tx);

    // side selection: loader pushes, drainer pops
    always_comb begin
        if (dir == DIR_TX) begin
            req.push  = host_push;
            req.wdata = host_wdata;
            req.pop   = frm_pop;
        end else begin
            req.push  = frm_push;
            req.wdata = frm_wdata;
            req.pop   = host_pop;
        end
    end

    xfifo_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .push    (req.push),
        .pop     (req.pop),
        .wdata   (req.wdata),
        .rdata   (head),
        .count   (count),
        .push_ok (push_ok),
        .pop_ok  (pop_ok),
        .ovf_ev  (ovf_ev),
        .udf_ev  (udf_ev),
        .full    (full),
        .empty   (empty)
    );

    assign host_rdata = (dir == DIR_RX) ? head : '0;
    assign frm_rdata  = (dir == DIR_TX) ? head : '0;

    // direction-dependent level mark
    always_comb begin
        if (dir == DIR_TX)
            lvl_ev = pop_ok && !push_ok && (count == CNTW'(TX_LOW + 1));
        else
            lvl_ev = push_ok && !pop_ok && (count == CNTW'(RX_HIGH));
    end

    always_comb begin
        set_vec           = '0;
        set_vec[FB_TXEND] = tx_start || tx_done;
        set_vec[FB_RXEND] = rx_eof;
        set_vec[FB_LEVEL] = lvl_ev;
        set_vec[FB_CRC]   = err_crc;
        set_vec[FB_PAR]   = err_par;
        set_vec[FB_FRM]   = err_frm;
        set_vec[FB_OVF]   = ovf_ev;
        set_vec[FB_UDF]   = udf_ev;
    end

    xfifo_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .stat_rd  (stat_rd),
        .set_vec  (set_vec),
        .tx_done  (tx_done),
        .en_wr    (en_wr),
        .en_wdata (en_wdata),
        .flags    (stat_flags),
        .en       (en_q),
        .irq      (irq)
    );

    xfifo_txlen #(.LEN_W(LEN_W)) u_txlen (
        .clk     (clk),
        .rst     (rst),
        .wr      (txlen_wr),
        .wdata   (txlen_wdata),
        .tx_done (tx_done),
        .q       (txlen_q)
    );

    assign lvl_code   = empty ? '0 : LVLW'(count - CNTW'(1));
    assign stat_level = {full, empty, lvl_code};

    a_r2_idle_side_ignored: assert property (@(posedge clk) disable iff (rst)
        (!dir_tx && (host_push || frm_pop) && !frm_push && !host_pop && !flush)
        |=> $stable(stat_level));

    a_r7_tx_mark: assert property (@(posedge clk) disable iff (rst)
        (dir_tx && frm_pop && !host_push && !flush && !stat_rd &&
         stat_level == {2'b00, LVLW'(TX_LOW)}) |=> stat_flags[FB_LEVEL]);

    a_r8_rx_mark: assert property (@(posedge clk) disable iff (rst)
        (!dir_tx && frm_push && !host_pop && !flush && !stat_rd &&
         stat_level == {2'b00, LVLW'(RX_HIGH - 1)}) |=> stat_flags[FB_LEVEL]);

    a_r10_error_flags: assert property (@(posedge clk) disable iff (rst)
        (err_crc && err_par && err_frm) |=> (stat_flags[FB_FRM:FB_CRC] == 3'b111));

endmodule

// File: tb/tb_xfifo_top.sv
`timescale 1ns/1ps
module tb_xfifo_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        dir_tx, flush;
    logic        host_push, host_pop, frm_push, frm_pop;
    logic [7:0]  host_wdata, frm_wdata, host_rdata, frm_rdata;
    logic        tx_start, tx_done, rx_eof, err_crc, err_par, err_frm;
    logic        en_wr, stat_rd, irq, txlen_wr;
    logic [7:0]  en_wdata, en_q, stat_flags;
    logic [5:0]  stat_level;
    logic [11:0] txlen_wdata, txlen_q;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    xfifo_top dut (
        .clk(clk), .rst(rst), .dir_tx(dir_tx), .flush(flush),
        .host_push(host_push), .host_wdata(host_wdata), .host_pop(host_pop), .host_rdata(host_rdata),
        .frm_push(frm_push), .frm_wdata(frm_wdata), .frm_pop(frm_pop), .frm_rdata(frm_rdata),
        .tx_start(tx_start), .tx_done(tx_done), .rx_eof(rx_eof),
        .err_crc(err_crc), .err_par(err_par), .err_frm(err_frm),
        .en_wr(en_wr), .en_wdata(en_wdata), .en_q(en_q),
        .stat_rd(stat_rd), .stat_level(stat_level), .stat_flags(stat_flags), .irq(irq),
        .txlen_wr(txlen_wr), .txlen_wdata(txlen_wdata), .txlen_q(txlen_q)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_strobes();
        flush = 0; host_push = 0; host_pop = 0; frm_push = 0; frm_pop = 0;
        tx_start = 0; tx_done = 0; rx_eof = 0; err_crc = 0; err_par = 0; err_frm = 0;
        en_wr = 0; stat_rd = 0; txlen_wr = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        clear_strobes();
    endtask

    task automatic push_host(input logic [7:0] b);
        host_push = 1; host_wdata = b; tick();
    endtask

    task automatic push_frm(input logic [7:0] b);
        frm_push = 1; frm_wdata = b; tick();
    endtask

    task automatic read_status();
        stat_rd = 1; tick();
    endtask

    task automatic t_reset();
        rst = 1; dir_tx = 1; host_wdata = 0; frm_wdata = 0; en_wdata = 0; txlen_wdata = 0;
        clear_strobes();
        repeat (3) @(posedge clk);
        #1 rst = 0;
        check("R1 level", stat_level, 6'h10);
        check("R1 flags", stat_flags, 8'h00);
        check("R1 irq", irq, 0);
        check("R1 enables", en_q, 8'h3C);
        check("R1 txlen", txlen_q, 0);
    endtask

    task automatic t_tx_fill_drain();
        dir_tx = 1;
        for (int i = 0; i < 8; i++) push_host(8'hA0 + 8'(i));
        check("R3 eight bytes read 7", stat_level, 6'h07);
        frm_push = 1; frm_wdata = 8'h55; tick();
        check("R2 framer push ignored in tx", stat_level, 6'h07);
        for (int i = 8; i < 12; i++) push_host(8'hA0 + 8'(i));
        check("R3 full", stat_level, 6'h2B);
        check("R2 host rdata zero in tx", host_rdata, 0);
        host_pop = 1; tick();
        check("R2 host pop ignored in tx", stat_level, 6'h2B);
        check("R7 no mark while filling", stat_flags, 8'h00);
        push_host(8'hEE);
        check("R4 overflow count", stat_level, 6'h2B);
        check("R4 overflow flag", stat_flags, 8'h40);
        read_status();
        check("R11 read clears", stat_flags, 8'h00);
        for (int i = 0; i < 9; i++) begin
            check("R3 order", frm_rdata, 8'hA0 + 8'(i));
            if (i == 8) check("R7 no mark above 4", stat_flags, 8'h00);
            frm_pop = 1; tick();
        end
        check("R3 level after drain", stat_level, 6'h02);
        check("R7 low-water flag", stat_flags, 8'h04);
        frm_pop = 1; host_push = 1; host_wdata = 8'hB0; tick();
        check("R7 pop with push no change", stat_level, 6'h02);
        flush = 1; host_push = 1; host_wdata = 8'h11; tick();
        check("R6 flush empties", stat_level, 6'h10);
    endtask

    task automatic t_underflow_irq();
        read_status();
        check("R5 rdata zero when empty", frm_rdata, 0);
        frm_pop = 1; tick();
        check("R5 underflow flag", stat_flags, 8'h80);
        check("R5 count stays 0", stat_level, 6'h10);
        check("R11 masked flag no irq", irq, 0);
        en_wr = 1; en_wdata = 8'hFF; tick();
        check("R11 enabled flag irq", irq, 1);
        read_status();
        check("R11 irq cleared by read", irq, 0);
    endtask

    task automatic t_tx_end();
        txlen_wr = 1; txlen_wdata = 12'h123; tick();
        check("R12 length write", txlen_q, 12'h123);
        tx_start = 1; tick();
        check("R9 flag visible at start", stat_flags, 8'h01);
        check("R9 no irq before end", irq, 0);
        tx_done = 1; tick();
        check("R9 irq at end", irq, 1);
        check("R12 cleared at end", txlen_q, 0);
        tx_done = 1; txlen_wr = 1; txlen_wdata = 12'h0A5; tick();
        check("R12 write wins", txlen_q, 12'h0A5);
        read_status();
        check("R9 cleared", irq, 0);
    endtask

    task automatic t_rx();
        dir_tx = 0;
        for (int i = 0; i < 5; i++) push_frm(8'hC0 + 8'(i));
        check("R8 short frame no level flag", stat_flags, 8'h00);
        rx_eof = 1; tick();
        check("R8 short frame end flag", stat_flags, 8'h02);
        check("R2 frm rdata zero in rx", frm_rdata, 0);
        for (int i = 0; i < 5; i++) begin
            check("R3 rx order", host_rdata, 8'hC0 + 8'(i));
            host_pop = 1; tick();
        end
        read_status();
        for (int i = 0; i < 8; i++) push_frm(8'h10 + 8'(i));
        check("R8 eight bytes no flag", stat_flags, 8'h00);
        push_frm(8'h18);
        check("R8 ninth byte level flag", stat_flags, 8'h04);
        check("R3 nine bytes read 8", stat_level, 6'h08);
        flush = 1; tick();
        read_status();
    endtask

    task automatic t_errors();
        en_wr = 1; en_wdata = 8'h08; tick();
        err_crc = 1; tick();
        check("R10 crc flag", stat_flags, 8'h08);
        check("R11 crc irq", irq, 1);
        read_status();
        err_frm = 1; tick();
        check("R10 framing flag", stat_flags, 8'h20);
        check("R11 masked framing no irq", irq, 0);
        stat_rd = 1; err_par = 1; tick();
        check("R11 set beats clear", stat_flags, 8'h10);
        read_status();
        check("R11 all clear", stat_flags, 8'h00);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 50000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected<50000", cyc);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        t_reset();
        t_tx_fill_drain();
        t_underflow_irq();
        t_tx_end();
        t_rx();
        t_errors();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule